// File: doc/BRIEF.md
# DMA Channel Control and Status Logic

This block is the software-facing control logic for a single DMA channel. A small register port reaches two 8-bit registers: a mode register, which starts, halts and configures the channel, and a status register, which holds the busy flag and sticky event flags. The block does not move data. It issues one-cycle request pulses to a separate transfer engine and takes completion, segment, descriptor and error indications back from it.

The channel-start bit acts on its edges. Its effect depends on the direction of the edge and on whether the channel is busy: a rising edge starts a new transfer or resumes a halted one, and a falling edge halts a busy channel. The channel runs either as one direct transfer or as a chain of descriptor segments. A continue bit asks the engine to re-fetch from the current descriptor, and the block clears that bit after every descriptor read. A mask decides whether a transfer error stops the channel. A level interrupt reports the end of the whole transfer.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, both registers read 0x00 and every request output and `irq` is low.
- R2: `reg_sel`=0 selects the mode register and `reg_sel`=1 selects the status register. `reg_rdata` shows the selected register combinationally. Mode bits: bit0 start, bit1 continue, bit2 transfer mode (1 direct, 0 chaining), bit3 error mask, bit7 end-of-transfer interrupt enable. Mode bits 6..4 always read 0.
- R3: A mode write that takes bit0 from 0 to 1 while the channel is not busy gives a one-cycle `eng_start` pulse in the cycle after the write and sets the busy flag (status bit2).
- R4: A mode write that takes bit0 from 0 to 1 while the channel is busy gives a one-cycle `eng_resume` pulse in the cycle after the write.
- R5: A mode write that takes bit0 from 1 to 0 while busy gives a one-cycle `eng_halt` pulse and busy stays set. The same edge while not busy produces no pulse.
- R6: A mode write that leaves bit0 unchanged produces no request pulse, and each start-bit edge produces exactly one pulse.
- R7: `eng_cont` is high only while the continue bit is set and the mode is chaining. `eng_desc_rd` clears the continue bit.
- R8: With the error mask clear, `eng_xfer_err` sets status bit7, clears busy and gives an `eng_halt` pulse. With the mask set, it does none of these.
- R9: `eng_seg_done` sets status bit1 in chaining mode only. `eng_done` sets status bit0 and clears busy. Busy changes through no other path.
- R10: Writing 1 to status bit0, bit1 or bit7 clears that bit, and writing 0 leaves it. The busy bit ignores writes. An event that sets a flag wins over a clear written in the same cycle.
- R11: `irq` is high while status bit0 and mode bit7 are both set. It drops when software clears bit0, and it stays low while the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| eng_start | output | 1 | Pulse: begin a new transfer |
| eng_resume | output | 1 | Pulse: continue from the halt point |
| eng_halt | output | 1 | Pulse: stop the transfer |
| eng_cont | output | 1 | Level: re-fetch from the current descriptor |
| eng_done | input | 1 | Whole transfer finished |
| eng_seg_done | input | 1 | One chained segment finished |
| eng_desc_rd | input | 1 | Engine read a descriptor |
| eng_xfer_err | input | 1 | Transfer error seen |
| irq | output | 1 | End-of-transfer interrupt level |

## Verification
The assertions assume that the engine raises `eng_done` and `eng_xfer_err` only on the cycles it is told about, that no register write lands in the same cycle as a descriptor read, and that the interrupt property is not disturbed by a mode write in the same cycle as completion. The stimulus drives at most one engine indication per cycle. It never pairs a mode write with `eng_desc_rd`, and it only combines an event with a write on purpose, in the status-register collision case.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W   = 8;
  // mode register bit positions
  localparam int M_START  = 0;
  localparam int M_CONT   = 1;
  localparam int M_DIRECT = 2;
  localparam int M_EMASK  = 3;
  localparam int M_EOTIE  = 7;
  // status register bit positions
  localparam int S_DONE = 0;
  localparam int S_SEG  = 1;
  localparam int S_BUSY = 2;
  localparam int S_ERR  = 7;

  typedef struct packed {
    logic eotie;
    logic emask;
    logic direct;
    logic cont;
    logic start;
  } mode_t;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_START  = 2'd1,
    REQ_RESUME = 2'd2,
    REQ_HALT   = 2'd3
  } req_e;
endpackage

// File: rtl/dma_chan_rst_sync.sv
module dma_chan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dma_chan_mode_reg.sv
module dma_chan_mode_reg
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic [REG_W-1:0] wdata,
  input  logic             desc_rd,
  output mode_t            mode
);
  mode_t mode_q, mode_d;
  logic  mode_en;

  assign mode_en = wr_mode | desc_rd;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.start  = wdata[M_START];
      mode_d.cont   = wdata[M_CONT];
      mode_d.direct = wdata[M_DIRECT];
      mode_d.emask  = wdata[M_EMASK];
      mode_d.eotie  = wdata[M_EOTIE];
    end
    // hardware clear after every descriptor fetch
    if (desc_rd) mode_d.cont = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/dma_chan_start_dec.sv
module dma_chan_start_dec
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_mode,
  input  logic new_start,
  input  logic old_start,
  input  logic busy,
  input  logic err_halt,
  output req_e req_now,
  output logic start_p,
  output logic resume_p,
  output logic halt_p
);
  req_e req_q;
  logic rise, fall;

  assign rise = wr_mode &  new_start & ~old_start;
  assign fall = wr_mode & ~new_start &  old_start;

  always_comb begin
    req_now = REQ_NONE;
    if (err_halt)          req_now = REQ_HALT;
    else if (rise & ~busy) req_now = REQ_START;
    else if (rise &  busy) req_now = REQ_RESUME;
    else if (fall &  busy) req_now = REQ_HALT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= REQ_NONE;
    else        req_q <= req_now;
  end

  assign start_p  = (req_q == REQ_START);
  assign resume_p = (req_q == REQ_RESUME);
  assign halt_p   = (req_q == REQ_HALT);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic             start_req,
  input  logic             done_ev,
  input  logic             seg_ev,
  input  logic             err_ev,
  output logic             busy,
  output logic             done_f,
  output logic             seg_f,
  output logic             err_f
);
  logic busy_d, done_d, seg_d, err_d;
  logic st_en;

  assign st_en = wr_stat | start_req | done_ev | seg_ev | err_ev;

  always_comb begin
    busy_d = busy;
    if (start_req)        busy_d = 1'b1;
    if (done_ev | err_ev) busy_d = 1'b0;

    done_d = done_f;
    seg_d  = seg_f;
    err_d  = err_f;
    if (wr_stat & wdata[S_DONE]) done_d = 1'b0;
    if (wr_stat & wdata[S_SEG])  seg_d  = 1'b0;
    if (wr_stat & wdata[S_ERR])  err_d  = 1'b0;
    if (done_ev) done_d = 1'b1;
    if (seg_ev)  seg_d  = 1'b1;
    if (err_ev)  err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_f <= 1'b0;
      seg_f  <= 1'b0;
      err_f  <= 1'b0;
    end else if (st_en) begin
      busy   <= busy_d;
      done_f <= done_d;
      seg_f  <= seg_d;
      err_f  <= err_d;
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             eng_start,
  output logic             eng_resume,
  output logic             eng_halt,
  output logic             eng_cont,
  input  logic             eng_done,
  input  logic             eng_seg_done,
  input  logic             eng_desc_rd,
  input  logic             eng_xfer_err,
  output logic             irq
);
  logic  rst_sync_n;
  logic  wr_mode, wr_stat;
  mode_t mode;
  req_e  req_now;
  logic  busy, done_flag, seg_flag, err_flag;
  logic  err_stop;
  logic  cont_bit, direct_bit, emask_bit, eotie_bit;

  dma_chan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_mode = reg_wr_en & ~reg_sel;
  assign wr_stat = reg_wr_en &  reg_sel;

  dma_chan_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_mode (wr_mode),
    .wdata   (reg_wdata),
    .desc_rd (eng_desc_rd),
    .mode    (mode)
  );

  assign cont_bit   = mode.cont;
  assign direct_bit = mode.direct;
  assign emask_bit  = mode.emask;
  assign eotie_bit  = mode.eotie;
  assign err_stop   = eng_xfer_err & ~emask_bit;

  dma_chan_start_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_mode   (wr_mode),
    .new_start (reg_wdata[M_START]),
    .old_start (mode.start),
    .busy      (busy),
    .err_halt  (err_stop & busy),
    .req_now   (req_now),
    .start_p   (eng_start),
    .resume_p  (eng_resume),
    .halt_p    (eng_halt)
  );

  dma_chan_status u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_stat   (wr_stat),
    .wdata     (reg_wdata),
    .start_req (req_now == REQ_START),
    .done_ev   (eng_done),
    .seg_ev    (eng_seg_done & ~direct_bit),
    .err_ev    (err_stop),
    .busy      (busy),
    .done_f    (done_flag),
    .seg_f     (seg_flag),
    .err_f     (err_flag)
  );

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[M_START]  = mode.start;
      reg_rdata[M_CONT]   = mode.cont;
      reg_rdata[M_DIRECT] = mode.direct;
      reg_rdata[M_EMASK]  = mode.emask;
      reg_rdata[M_EOTIE]  = mode.eotie;
    end else begin
      reg_rdata[S_DONE] = done_flag;
      reg_rdata[S_SEG]  = seg_flag;
      reg_rdata[S_BUSY] = busy;
      reg_rdata[S_ERR]  = err_flag;
    end
  end

  assign eng_cont = cont_bit & ~direct_bit;
  assign irq      = done_flag & eotie_bit;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr_en,
  input logic reg_sel,
  input logic eng_start,
  input logic eng_resume,
  input logic eng_halt,
  input logic eng_cont,
  input logic eng_done,
  input logic eng_desc_rd,
  input logic eng_xfer_err,
  input logic irq,
  input logic busy,
  input logic err_flag,
  input logic cont_bit,
  input logic direct_bit,
  input logic emask_bit,
  input logic eotie_bit
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);                                            // R3
  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> $past(busy));                                    // R4
  AST_HALT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_halt |-> $past(busy));                                      // R5
  AST_CONT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cont |-> !direct_bit);                                      // R7
  AST_DESC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_desc_rd |=> !cont_bit);                                     // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_xfer_err && !emask_bit && busy) |=> (!busy && err_flag && eng_halt)); // R8
  AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_xfer_err && emask_bit && !err_flag) |=> !err_flag);        // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done && !eng_xfer_err) |=> busy);                 // R9
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eotie_bit && !(reg_wr_en && !reg_sel)) |=> irq);   // R11
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .reg_wr_en    (reg_wr_en),
  .reg_sel      (reg_sel),
  .eng_start    (eng_start),
  .eng_resume   (eng_resume),
  .eng_halt     (eng_halt),
  .eng_cont     (eng_cont),
  .eng_done     (eng_done),
  .eng_desc_rd  (eng_desc_rd),
  .eng_xfer_err (eng_xfer_err),
  .irq          (irq),
  .busy         (busy),
  .err_flag     (err_flag),
  .cont_bit     (cont_bit),
  .direct_bit   (direct_bit),
  .emask_bit    (emask_bit),
  .eotie_bit    (eotie_bit)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  localparam int CLK_NS = 8;

  typedef enum int {OB_RDATA, OB_START, OB_RESUME, OB_HALT, OB_CONT, OB_IRQ} obs_e;
  typedef struct {
    obs_e        id;
    logic [7:0]  exp;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic       eng_start, eng_resume, eng_halt, eng_cont;
  logic       eng_done, eng_seg_done, eng_desc_rd, eng_xfer_err, irq;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  always #(CLK_NS/2) clk = ~clk;

  dma_chan_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_resume(eng_resume), .eng_halt(eng_halt), .eng_cont(eng_cont),
    .eng_done(eng_done), .eng_seg_done(eng_seg_done), .eng_desc_rd(eng_desc_rd),
    .eng_xfer_err(eng_xfer_err), .irq(irq)
  );

  function automatic logic [7:0] observe(obs_e id);
    case (id)
      OB_RDATA:  return reg_rdata;
      OB_START:  return {7'b0, eng_start};
      OB_RESUME: return {7'b0, eng_resume};
      OB_HALT:   return {7'b0, eng_halt};
      OB_CONT:   return {7'b0, eng_cont};
      default:   return {7'b0, irq};
    endcase
  endfunction

  // monitor: compares queued expectations just after each rising edge
  always @(posedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e   = sb_q.pop_front();
      act = observe(e.id);
      checks++;
      if (act !== e.exp) begin
        failures++;
        $display("FAIL %s %s actual=%02h expected=%02h", e.tag, e.id.name(), act, e.exp);
      end
    end
  end

  task automatic expect_v(obs_e id, logic [7:0] v, string tag);
    exp_t e;
    e.id = id; e.exp = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // driver: one clock cycle of stimulus; expectations refer to after the next edge
  task automatic cyc(logic wr, logic sel, logic [7:0] wd,
                     logic dn, logic sg, logic dr, logic er);
    @(negedge clk);
    reg_wr_en = wr; reg_sel = sel; reg_wdata = wd;
    eng_done = dn; eng_seg_done = sg; eng_desc_rd = dr; eng_xfer_err = er;
  endtask

  task automatic wr_mode(logic [7:0] wd); cyc(1, 0, wd, 0, 0, 0, 0); endtask
  task automatic wr_stat(logic [7:0] wd); cyc(1, 1, wd, 0, 0, 0, 0); endtask
  task automatic idle(logic sel);         cyc(0, sel, 8'h00, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 0; reg_sel = 0; reg_wdata = 0;
    eng_done = 0; eng_seg_done = 0; eng_desc_rd = 0; eng_xfer_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    idle(0);
    expect_v(OB_RDATA, 8'h00, "R1"); expect_v(OB_START, 0, "R1");
    expect_v(OB_HALT, 0, "R1"); expect_v(OB_CONT, 0, "R1"); expect_v(OB_IRQ, 0, "R1");
    idle(1);  expect_v(OB_RDATA, 8'h00, "R1");

    // R3 start in direct mode with interrupt enable
    wr_mode(8'h85); expect_v(OB_START, 1, "R3"); expect_v(OB_RDATA, 8'h85, "R2");
    idle(1);        expect_v(OB_START, 0, "R6"); expect_v(OB_RDATA, 8'h04, "R3");
    // R2 reserved bits, R6 no edge -> no pulse
    wr_mode(8'hF5); expect_v(OB_RDATA, 8'h85, "R2");
    expect_v(OB_START, 0, "R6"); expect_v(OB_RESUME, 0, "R6"); expect_v(OB_HALT, 0, "R6");
    // R5 halt while busy
    wr_mode(8'h84); expect_v(OB_HALT, 1, "R5");
    idle(1);        expect_v(OB_HALT, 0, "R6"); expect_v(OB_RDATA, 8'h04, "R5");
    // R4 resume while busy
    wr_mode(8'h85); expect_v(OB_RESUME, 1, "R4"); expect_v(OB_START, 0, "R4");
    // R9 done, R11 interrupt
    cyc(0, 1, 8'h00, 1, 0, 0, 0); expect_v(OB_RDATA, 8'h01, "R9"); expect_v(OB_IRQ, 1, "R11");
    idle(1);        expect_v(OB_IRQ, 1, "R11");
    // R10 write 0 keeps, write 1 clears; R11 irq drops
    wr_stat(8'h00); expect_v(OB_RDATA, 8'h01, "R10");
    wr_stat(8'h01); expect_v(OB_RDATA, 8'h00, "R10"); expect_v(OB_IRQ, 0, "R11");
    // R5 falling edge while idle ignored
    wr_mode(8'h84); expect_v(OB_HALT, 0, "R5"); expect_v(OB_RDATA, 8'h84, "R5");

    // chaining mode with continue, R7
    wr_mode(8'h03); expect_v(OB_START, 1, "R3"); expect_v(OB_CONT, 1, "R7");
    cyc(0, 1, 8'h00, 0, 1, 0, 0); expect_v(OB_RDATA, 8'h06, "R9");
    cyc(0, 1, 8'h00, 0, 0, 1, 0); expect_v(OB_CONT, 0, "R7");
    wr_mode(8'h07); expect_v(OB_CONT, 0, "R7"); expect_v(OB_RESUME, 0, "R6");
    wr_mode(8'h03); expect_v(OB_CONT, 1, "R7");
    // R8 unmasked error
    cyc(0, 1, 8'h00, 0, 0, 0, 1); expect_v(OB_RDATA, 8'h82, "R8"); expect_v(OB_HALT, 1, "R8");
    // R11 no interrupt while disabled
    cyc(0, 1, 8'h00, 1, 0, 0, 0); expect_v(OB_RDATA, 8'h83, "R9"); expect_v(OB_IRQ, 0, "R11");
    wr_stat(8'hFF); expect_v(OB_RDATA, 8'h00, "R10");

    // R8 masked error
    wr_mode(8'h08); expect_v(OB_HALT, 0, "R5");
    wr_mode(8'h09); expect_v(OB_START, 1, "R3");
    cyc(0, 1, 8'h00, 0, 0, 0, 1); expect_v(OB_RDATA, 8'h04, "R8"); expect_v(OB_HALT, 0, "R8");
    // R10 busy read-only
    wr_stat(8'h04); expect_v(OB_RDATA, 8'h04, "R10");
    // R10 set wins over same-cycle clear
    cyc(1, 1, 8'h01, 1, 0, 0, 0); expect_v(OB_RDATA, 8'h01, "R10");
    // R9 segment event ignored in direct mode
    wr_mode(8'h0D); expect_v(OB_START, 0, "R6");
    cyc(0, 1, 8'h00, 0, 1, 0, 0); expect_v(OB_RDATA, 8'h01, "R9");

    idle(1);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule